// File: doc/BRIEF.md
# Clock Fan-out Configuration Target (Two-Wire Block Access)

This block is the configuration port of a twelve-pair differential clock fan-out buffer. It acts as a target on a two-wire serial bus. It holds eight 8-bit registers. Two of these registers drive a parallel enable vector, with one bit for each output pair. The bus lines SCL and SDA are sampled by a faster system clock. The target drives the bus through an open-drain pull-down: when `sda_pull_o` is high, SDA is pulled low.

A host writes with address byte 0xD2. The target acknowledges the next two bytes and throws their values away. Further data bytes fill the registers from byte 0 upward, and the host may stop after any whole byte. A host reads with address byte 0xD3. The target returns a count byte of 8, then the register bytes in index order. A level on a mode-select pin appears in the top bit of register byte 6.

Top module: `fanout_cfg_target`

## Requirements
- R1: After reset every register bit reads 1, `pair_en_o` is 12'hFFF and `sda_pull_o` is 0.
- R2: Address byte 0xD2 (write) and address byte 0xD3 (read) are acknowledged by holding SDA low during the ninth SCL pulse. For any other address byte, the target leaves SDA released and acknowledges nothing until the next start condition.
- R3: In a write, the two bytes that follow the address (command and count) are each acknowledged. Their values leave every register unchanged.
- R4: Write data bytes load register bytes 0, 1, 2 and so on in that order, and each is acknowledged. A stop after any whole byte keeps the bytes already loaded and leaves the others unchanged.
- R5: Write data bytes after the eighth are acknowledged and change no register.
- R6: A read returns the count byte 0x08, then register bytes 0 to 7, each sent MSB first. While the host keeps acknowledging, the byte sequence wraps back to byte 0. A host non-acknowledge ends the read.
- R7: Bit 7 of register byte 6 always reads the mode-select pin level, and writes to it have no effect. Bits 6 to 4 of byte 6 are stored and read back as written.
- R8: `pair_en_o[11:8]` equals register byte 6 bits 3..0, and `pair_en_o[7:0]` equals register byte 7 bits 7..0. A 1 enables a pair.
- R9: A repeated start inside a transfer restarts address reception, and the following write data again begins at register byte 0.
- R10: `sda_pull_o` changes only while SCL is low. A start or stop (SDA falling or rising while SCL is high) is recognized in any state, and a stop leaves SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull_o | output | 1 | 1 pulls SDA low |
| mode_sel_i | input | 1 | Mode-select pin (1 = DDR-only, 0 = mixed) |
| pair_en_o | output | 12 | Output-pair enables, bit n for pair n |

## Verification
The assertions assume a well-behaved host. Each SCL low and high phase lasts many system clocks. SDA changes only while SCL is low, except when the host forms a start or stop. The host never issues a start or stop while the target is holding SDA low. The bench host meets these conditions: it waits a fixed quarter-bit of system clocks between every line change, so the synchronizer delay never lines up an SDA change with an SCL edge. The mode pin is changed only while the bus is idle.

// File: rtl/fanout_cfg_target.sv
module fanout_cfg_target #(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter logic [7:0] RD_COUNT = 8'h08
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_pull_o,
  input  logic        mode_sel_i,
  output logic [11:0] pair_en_o
);
  localparam int NREG = 8;
  localparam int IW   = $clog2(NREG);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_RXEND, S_ACK, S_TX, S_TXACK} st_t;

  logic scl_m, scl_s, scl_q, sda_m, sda_s, sda_q, mode_m, mode_s;
  st_t         state;
  logic [2:0]  bitcnt;
  logic [1:0]  phase;
  logic        rd, host_ack;
  logic [7:0]  shreg, txsh;
  logic [IW:0] widx;
  logic [IW-1:0] ridx;
  logic [7:0]  regs [0:NREG-1];
  logic [7:0]  rd_byte;

  wire start_det = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  wire scl_rise  = scl_s & ~scl_q;
  wire scl_fall  = ~scl_s & scl_q;

  assign rd_byte    = (ridx == IW'(6)) ? {mode_s, regs[6][6:0]} : regs[ridx];
  assign sda_pull_o = (state == S_ACK) | ((state == S_TX) & ~txsh[7]);
  assign pair_en_o  = {regs[6][3:0], regs[7]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {scl_m, scl_s, scl_q, sda_m, sda_s, sda_q} <= 6'h3F;
      {mode_m, mode_s} <= 2'b00;
      state <= S_IDLE;
      bitcnt <= '0;
      phase <= '0;
      rd <= 1'b0;
      host_ack <= 1'b0;
      shreg <= '0;
      txsh <= '1;
      widx <= '0;
      ridx <= '0;
      for (int i = 0; i < NREG; i++) regs[i] <= 8'hFF;
    end else begin
      scl_m <= scl_i;  scl_s <= scl_m;  scl_q <= scl_s;
      sda_m <= sda_i;  sda_s <= sda_m;  sda_q <= sda_s;
      mode_m <= mode_sel_i;  mode_s <= mode_m;
      if (start_det) begin
        state <= S_RX;
        bitcnt <= '0;
        phase <= '0;
        widx <= '0;
      end else if (stop_det) begin
        state <= S_IDLE;
      end else begin
        case (state)
          S_RX: if (scl_rise) begin
            shreg <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == 3'd7) state <= S_RXEND;
          end
          S_RXEND: if (scl_fall) begin
            if (phase == 2'd0) begin
              if (shreg[7:1] == DEV_ADDR) begin
                rd <= shreg[0];
                state <= S_ACK;
              end else begin
                state <= S_IDLE;
              end
            end else begin
              state <= S_ACK;
              if (phase == 2'd3 && !widx[IW]) begin
                regs[widx[IW-1:0]] <= shreg;
                widx <= widx + 1'b1;
              end
            end
          end
          S_ACK: if (scl_fall) begin
            bitcnt <= '0;
            if (phase == 2'd0 && rd) begin
              state <= S_TX;
              txsh <= RD_COUNT;
              ridx <= '0;
            end else begin
              state <= S_RX;
              if (phase != 2'd3) phase <= phase + 2'd1;
            end
          end
          S_TX: if (scl_fall) begin
            if (bitcnt == 3'd7) begin
              state <= S_TXACK;
            end else begin
              txsh <= {txsh[6:0], 1'b0};
              bitcnt <= bitcnt + 3'd1;
            end
          end
          S_TXACK: begin
            if (scl_rise) host_ack <= ~sda_s;
            if (scl_fall) begin
              if (host_ack) begin
                state <= S_TX;
                bitcnt <= '0;
                txsh <= rd_byte;
                ridx <= ridx + 1'b1;
              end else begin
                state <= S_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_o) |-> !scl_s); // R10
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_pull_o); // R10
  AST_START_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state == S_RX && bitcnt == 3'd0 && phase == 2'd0 && widx == '0)); // R9
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> !sda_pull_o); // R2
  AST_EN_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pair_en_o) |-> $past(state == S_RXEND && phase == 2'd3 && scl_fall)); // R8
endmodule

// File: tb/fanout_cfg_target_tb.sv
module fanout_cfg_target_tb;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 12;

  logic clk = 0, rst_n = 0, host_scl = 1, host_sda = 1, mode_sel = 1;
  logic sda_pull;
  logic [11:0] pair_en;
  wire sda_bus = host_sda & ~sda_pull;
  int nvec = 0, nbad = 0, pull_hi_changes = 0;
  logic prev_pull = 0;
  logic [7:0] rb [0:15];
  logic ack;

  always #(CLK_PERIOD/2) clk = ~clk;

  fanout_cfg_target u_dut (.clk(clk), .rst_n(rst_n), .scl_i(host_scl), .sda_i(sda_bus),
    .sda_pull_o(sda_pull), .mode_sel_i(mode_sel), .pair_en_o(pair_en));

  localparam logic [8:0] VEC [0:7] = '{
    {8'hD2,1'b1}, {8'hD3,1'b1}, {8'hD0,1'b0}, {8'hD1,1'b0},
    {8'hD4,1'b0}, {8'h92,1'b0}, {8'h53,1'b0}, {8'hFE,1'b0}};

  always @(negedge clk) begin
    if (rst_n && sda_pull !== prev_pull && host_scl) pull_hi_changes++;
    prev_pull = sda_pull;
  end

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic qw;
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start;
    host_sda = 1; qw; host_scl = 1; qw; host_sda = 0; qw; host_scl = 0; qw;
  endtask

  task automatic bus_stop;
    host_sda = 0; qw; host_scl = 1; qw; host_sda = 1; qw;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic got_ack);
    for (int i = 7; i >= 0; i--) begin
      host_sda = b[i]; qw; host_scl = 1; qw; host_scl = 0; qw;
    end
    host_sda = 1; qw; host_scl = 1; qw;
    got_ack = ~sda_bus;
    host_scl = 0; qw;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    host_sda = 1;
    for (int i = 7; i >= 0; i--) begin
      qw; host_scl = 1; qw; b[i] = sda_bus; host_scl = 0;
    end
    qw; host_sda = ~give_ack; qw; host_scl = 1; qw; host_scl = 0; qw; host_sda = 1;
  endtask

  task automatic read_regs(input int n, input string tag);
    logic a;
    bus_start;
    send_byte(8'hD3, a);
    chk(a, 1, {tag, " R2 read addr ack"});
    for (int i = 0; i <= n; i++) recv_byte(i != n, rb[i]);
    bus_stop;
  endtask

  task automatic write_regs(input logic [7:0] cmd, input logic [7:0] cnt,
                            input logic [7:0] d [0:15], input int n, input logic do_stop);
    logic a;
    bus_start;
    send_byte(8'hD2, a);  chk(a, 1, "R2 write addr ack");
    send_byte(cmd, a);    chk(a, 1, "R3 command ack");
    send_byte(cnt, a);    chk(a, 1, "R3 count ack");
    for (int i = 0; i < n; i++) begin
      send_byte(d[i], a);
      chk(a, 1, (i < 8) ? "R4 data ack" : "R5 extra data ack");
    end
    if (do_stop) bus_stop;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    logic [7:0] d [0:15];
    logic [7:0] b;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk(pair_en, 12'hFFF, "R1 reset enables");
    chk(sda_pull, 0, "R1 reset SDA released");

    for (int v = 0; v < 8; v++) begin
      bus_start;
      send_byte(VEC[v][8:1], ack);
      chk(ack, VEC[v][0], "R2 address vector");
      if (VEC[v][0] && VEC[v][1]) begin
        recv_byte(0, b);
        chk(b, 8'h08, "R6 count byte");
      end else if (!VEC[v][0]) begin
        send_byte(8'h00, ack);
        chk(ack, 0, "R2 ignored after foreign address");
        chk(pair_en, 12'hFFF, "R2 foreign write no effect");
      end
      bus_stop;
    end

    read_regs(8, "R1");
    chk(rb[0], 8'h08, "R6 count");
    for (int i = 1; i <= 8; i++) chk(rb[i], 8'hFF, "R1 reset register value");

    d[0] = 8'h11; d[1] = 8'h22; d[2] = 8'h33;
    write_regs(8'h5A, 8'h03, d, 3, 1);
    chk(pair_en, 12'hFFF, "R4 untouched bytes keep enables");
    read_regs(8, "R4");
    chk(rb[1], 8'h11, "R4 byte0");
    chk(rb[2], 8'h22, "R4 byte1");
    chk(rb[3], 8'h33, "R4 byte2");
    chk(rb[4], 8'hFF, "R4 byte3 unchanged");
    chk(rb[7], 8'hFF, "R3 byte6 not hit by cmd/count");

    for (int i = 0; i < 8; i++) d[i] = 8'hA0 + 8'(i);
    d[6] = 8'h55; d[7] = 8'h3C; d[8] = 8'h00; d[9] = 8'h00;
    write_regs(8'hFF, 8'h00, d, 10, 1);
    chk(pair_en, 12'h53C, "R8 enables from bytes 6 and 7");
    read_regs(8, "R5");
    chk(rb[1], 8'hA0, "R5 byte0 not overwritten by extras");
    chk(rb[6], 8'hA5, "R4 byte5");
    chk(rb[7], 8'hD5, "R7 byte6 bit7 = pin 1, bits 6:4 stored");
    chk(rb[8], 8'h3C, "R5 byte7 not overwritten by extras");

    mode_sel = 0;
    repeat (10) @(negedge clk);
    read_regs(8, "R7");
    chk(rb[7], 8'h55, "R7 byte6 bit7 = pin 0");
    mode_sel = 1;
    repeat (10) @(negedge clk);

    read_regs(10, "R6");
    chk(rb[9], 8'hA0, "R6 wrap to byte0");
    chk(rb[10], 8'hA1, "R6 wrap to byte1");

    d[0] = 8'h77;
    write_regs(8'h00, 8'h01, d, 1, 0);
    d[0] = 8'h66;
    write_regs(8'h00, 8'h01, d, 1, 1);
    read_regs(2, "R9");
    chk(rb[1], 8'h66, "R9 repeated start restarts at byte0");
    chk(rb[2], 8'hA1, "R9 byte1 unchanged");

    chk(16'(pull_hi_changes), 0, "R10 SDA pull moved while SCL high");
    chk(sda_pull, 0, "R10 released after stop");

    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule